// File: doc/BRIEF.md
# SDRAM Bank Activation Timing Tracker

This block sits between a memory controller's command scheduler and the command pins of a four-bank SDRAM. Each cycle it takes one requested command (NOP, ACTIVE, READ, WRITE or PRECHARGE) with a bank number and an address. It keeps, for every bank, whether a row is open and which row that is. It also keeps the countdown timers that space commands apart. A request that breaks no rule is granted and sent to the pins on the next clock edge. A request that would break a rule is stalled, and a NOP goes out in its place.

Timing limits are given as nanosecond parameters together with the clock period in picoseconds. They are turned into whole clock counts at elaboration by rounding up. A test-mode force input pushes a request to the pins even when it is illegal. Each rule the forced command breaks sets its own sticky violation bit, which only reset clears.

Top module: `sdram_act_tracker`

## Requirements
- R1: A legal ACTIVE (req_cmd 1) is granted, and the addressed bit of bank_open reads 1 from the cycle after it is issued.
- R2: A READ (req_cmd 2) or WRITE (req_cmd 3) to a bank whose bank_open bit is 0 is stalled: grant is 0, stall is 1, and the pins show NOP on the next cycle.
- R3: A READ or WRITE to a bank is stalled until ceil(T_RCD_NS*1000/T_CK_PS) cycles after that bank's ACTIVE. With the defaults (20 ns, 10 ns clock) this is 2: stalled one cycle after the ACTIVE, granted two cycles after.
- R4: An ACTIVE to a bank whose bank_open bit is 1 is stalled.
- R5: Two ACTIVE commands to the same bank are at least ceil(T_RC_NS*1000/T_CK_PS) cycles apart. The default is 7: stalled at 6 cycles, granted at 7.
- R6: Two ACTIVE commands to any banks are at least ceil(T_RRD_NS*1000/T_CK_PS) cycles apart. The default 15 ns rounds up to 2 cycles.
- R7: A PRECHARGE (req_cmd 4) is always legal. It clears the bank's bank_open bit from the next cycle, and an ACTIVE to that bank is stalled for ceil(T_RP_NS*1000/T_CK_PS) cycles (default 2).
- R8: The pins are registered. The cycle after a request, {cs_n,ras_n,cas_n,we_n} is 0111 for NOP, 0011 for ACTIVE, 0101 for READ, 0100 for WRITE and 0010 for PRECHARGE. A stalled request or an undefined req_cmd (5 to 7) gives NOP. For an issued non-NOP command, ba and addr carry the request's bank and address.
- R9: With force_issue high, an illegal request still reaches the pins, while grant and stall still show its legality. Each broken rule sets a sticky bit of viol: bit0 access to a closed bank, bit1 row-to-column delay, bit2 ACTIVE to an open bank, bit3 same-bank ACTIVE spacing, bit4 ACTIVE-to-ACTIVE spacing, bit5 precharge time.
- R10: During reset and on the first edge after it, every bank is closed, viol is 0, the pins show NOP and cke is 0. From the first clock edge after reset is released, cke is 1.
- R11: row_hit is 1 exactly when the bank named by req_bank is open and the row stored by its last ACTIVE equals req_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_cmd | input | 3 | Requested command code |
| req_bank | input | 2 | Requested bank |
| req_addr | input | 11 | Row for ACTIVE, column for READ/WRITE |
| force_issue | input | 1 | Test mode: issue the request even if illegal |
| grant | output | 1 | Request is legal this cycle |
| stall | output | 1 | Request would break a timing or state rule |
| row_hit | output | 1 | Requested bank is open on req_addr |
| bank_open | output | 4 | Open flag per bank |
| viol | output | 6 | Sticky violation flags |
| cke | output | 1 | Clock enable pin |
| cs_n | output | 1 | Chip select pin |
| ras_n | output | 1 | Row strobe pin |
| cas_n | output | 1 | Column strobe pin |
| we_n | output | 1 | Write enable pin |
| ba | output | 2 | Bank address pins |
| addr | output | 11 | Address pins |

## Verification
On every cycle the assertions check that each running timer steps down by one, that an issued ACTIVE opens its bank and an issued PRECHARGE closes it, that a stalled request without force leaves NOP on the pins, that violation bits never clear, and that cke rises after reset. Only the bench scenarios show the exact cycle at which each spacing rule releases a stalled request, the pin pattern for each command, and the mix of violation bits that each forced command sets.

// File: rtl/sdram_act_pkg.sv
package sdram_act_pkg;

   localparam logic [2:0] CMD_NOP = 3'd0;
   localparam logic [2:0] CMD_ACT = 3'd1;
   localparam logic [2:0] CMD_RD  = 3'd2;
   localparam logic [2:0] CMD_WR  = 3'd3;
   localparam logic [2:0] CMD_PRE = 3'd4;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } pin_cmd_t;

   localparam pin_cmd_t PINS_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

   // Round a nanosecond limit up to whole clocks of a picosecond period.
   function automatic int ns_to_cyc(input int lim_ns, input int per_ps);
      return (lim_ns * 1000 + per_ps - 1) / per_ps;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic pin_cmd_t encode_cmd(input logic [2:0] cmd);
      pin_cmd_t p;
      case (cmd)
         CMD_ACT: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
         CMD_RD:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
         CMD_WR:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
         CMD_PRE: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
         default: p = PINS_NOP;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
   parameter int CW    = 3,
   parameter int GAP_C = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic zero_o
);
   initial begin
      assert (GAP_C >= 0 && GAP_C < (1 << CW) + 1)
         else $error("gap %0d does not fit counter width %0d", GAP_C, CW);
   end

   generate
      if (GAP_C <= 1) begin : g_free
         // A gap of one cycle or less is always met on the next edge.
         logic unused_in;
         assign unused_in = ^{clk, rst_n, load};
         assign zero_o    = 1'b1;
      end else begin : g_count
         localparam logic [CW-1:0] LOADV = CW'(GAP_C - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst_n)              cnt <= '0;
            else if (load)           cnt <= LOADV;
            else if (cnt != '0)      cnt <= cnt - CW'(1);
         end
         assign zero_o = (cnt == '0);

         // R3, R5, R6, R7: every running spacing timer steps down by one per clock
         assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt != '0 && !load) |=> (cnt == $past(cnt) - CW'(1)));
      end
   endgenerate
endmodule

// File: rtl/sdram_bank_ctx.sv
module sdram_bank_ctx #(
   parameter int CW    = 3,
   parameter int RCD_C = 2,
   parameter int RC_C  = 7,
   parameter int RP_C  = 2,
   parameter int ROW_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_iss,
   input  logic             pre_iss,
   input  logic [ROW_W-1:0] row_in,
   output logic             open_o,
   output logic [ROW_W-1:0] row_o,
   output logic             rcd_ok,
   output logic             rc_ok,
   output logic             rp_ok
);
   logic open_q;
   logic [ROW_W-1:0] row_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         row_q  <= '0;
      end else if (act_iss) begin
         open_q <= 1'b1;
         row_q  <= row_in;
      end else if (pre_iss) begin
         open_q <= 1'b0;
      end
   end

   sdram_gap_timer #(.CW(CW), .GAP_C(RCD_C)) i_rcd (
      .clk(clk), .rst_n(rst_n), .load(act_iss), .zero_o(rcd_ok));
   sdram_gap_timer #(.CW(CW), .GAP_C(RC_C)) i_rc (
      .clk(clk), .rst_n(rst_n), .load(act_iss), .zero_o(rc_ok));
   sdram_gap_timer #(.CW(CW), .GAP_C(RP_C)) i_rp (
      .clk(clk), .rst_n(rst_n), .load(pre_iss), .zero_o(rp_ok));

   assign open_o = open_q;
   assign row_o  = row_q;

   assert_act_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
      act_iss |=> open_o);
   assert_pre_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pre_iss |=> !open_o);
endmodule

// File: rtl/sdram_pin_drv.sv
module sdram_pin_drv
   import sdram_act_pkg::*;
#(
   parameter int BA_W  = 2,
   parameter int ROW_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       cmd_eff,
   input  logic [BA_W-1:0]  bank_in,
   input  logic [ROW_W-1:0] addr_in,
   output logic             cke,
   output pin_cmd_t         pins,
   output logic [BA_W-1:0]  ba,
   output logic [ROW_W-1:0] addr
);
   pin_cmd_t nxt;
   assign nxt = encode_cmd(cmd_eff);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cke  <= 1'b0;
         pins <= PINS_NOP;
         ba   <= '0;
         addr <= '0;
      end else begin
         cke  <= 1'b1;
         pins <= nxt;
         if (nxt != PINS_NOP) begin
            ba   <= bank_in;
            addr <= addr_in;
         end
      end
   end

   assert_cke_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> cke);
endmodule

// File: rtl/sdram_act_tracker.sv
module sdram_act_tracker
   import sdram_act_pkg::*;
#(
   parameter int T_CK_PS  = 10000,
   parameter int T_RCD_NS = 20,
   parameter int T_RC_NS  = 70,
   parameter int T_RRD_NS = 15,
   parameter int T_RP_NS  = 20,
   parameter int BANKS    = 4,
   parameter int ROW_W    = 11
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [2:0]                 req_cmd,
   input  logic [$clog2(BANKS)-1:0]   req_bank,
   input  logic [ROW_W-1:0]           req_addr,
   input  logic                       force_issue,
   output logic                       grant,
   output logic                       stall,
   output logic                       row_hit,
   output logic [BANKS-1:0]           bank_open,
   output logic [5:0]                 viol,
   output logic                       cke,
   output logic                       cs_n,
   output logic                       ras_n,
   output logic                       cas_n,
   output logic                       we_n,
   output logic [$clog2(BANKS)-1:0]   ba,
   output logic [ROW_W-1:0]           addr
);
   localparam int BA_W  = $clog2(BANKS);
   localparam int RCD_C = ns_to_cyc(T_RCD_NS, T_CK_PS);
   localparam int RC_C  = ns_to_cyc(T_RC_NS, T_CK_PS);
   localparam int RRD_C = ns_to_cyc(T_RRD_NS, T_CK_PS);
   localparam int RP_C  = ns_to_cyc(T_RP_NS, T_CK_PS);
   localparam int MAXC  = max2(max2(RCD_C, RC_C), max2(RRD_C, RP_C));
   localparam int CW    = (MAXC < 2) ? 1 : $clog2(MAXC);

   initial begin
      assert (T_CK_PS > 0) else $error("clock period must be positive");
      assert (BANKS == (1 << BA_W) && BANKS >= 2) else $error("bank count must be a power of two");
      assert (RC_C >= RRD_C) else $error("same-bank spacing shorter than any-bank spacing");
   end

   logic is_act, is_rw, is_pre;
   assign is_act = (req_cmd == CMD_ACT);
   assign is_rw  = (req_cmd == CMD_RD) || (req_cmd == CMD_WR);
   assign is_pre = (req_cmd == CMD_PRE);

   logic [BANKS-1:0] rcd_ok, rc_ok, rp_ok;
   logic [ROW_W-1:0] bank_row [BANKS];
   logic             rrd_ok;
   logic             issue;

   generate
      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         logic hit_b;
         assign hit_b = issue && (req_bank == BA_W'(b));
         sdram_bank_ctx #(
            .CW(CW), .RCD_C(RCD_C), .RC_C(RC_C), .RP_C(RP_C), .ROW_W(ROW_W)
         ) i_ctx (
            .clk(clk), .rst_n(rst_n),
            .act_iss(hit_b && is_act), .pre_iss(hit_b && is_pre),
            .row_in(req_addr), .open_o(bank_open[b]), .row_o(bank_row[b]),
            .rcd_ok(rcd_ok[b]), .rc_ok(rc_ok[b]), .rp_ok(rp_ok[b]));
      end
   endgenerate

   sdram_gap_timer #(.CW(CW), .GAP_C(RRD_C)) i_rrd (
      .clk(clk), .rst_n(rst_n), .load(issue && is_act), .zero_o(rrd_ok));

   // Rules broken by the current request, in viol bit order.
   logic       sel_open;
   logic [5:0] brk;
   assign sel_open = bank_open[req_bank];
   assign brk[0] = is_rw  && !sel_open;
   assign brk[1] = is_rw  && !rcd_ok[req_bank];
   assign brk[2] = is_act && sel_open;
   assign brk[3] = is_act && !rc_ok[req_bank];
   assign brk[4] = is_act && !rrd_ok;
   assign brk[5] = is_act && !rp_ok[req_bank];

   assign grant   = (brk == '0);
   assign stall   = !grant;
   assign issue   = grant || force_issue;
   assign row_hit = sel_open && (bank_row[req_bank] == req_addr);

   logic [5:0] viol_q;
   always_ff @(posedge clk) begin
      if (!rst_n) viol_q <= '0;
      else        viol_q <= viol_q | (brk & {6{force_issue}});
   end
   assign viol = viol_q;

   pin_cmd_t   pins;
   logic [2:0] cmd_eff;
   assign cmd_eff = issue ? req_cmd : CMD_NOP;

   sdram_pin_drv #(.BA_W(BA_W), .ROW_W(ROW_W)) i_pins (
      .clk(clk), .rst_n(rst_n), .cmd_eff(cmd_eff), .bank_in(req_bank),
      .addr_in(req_addr), .cke(cke), .pins(pins), .ba(ba), .addr(addr));

   assign cs_n  = pins.cs_n;
   assign ras_n = pins.ras_n;
   assign cas_n = pins.cas_n;
   assign we_n  = pins.we_n;

   assert_stall_nop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !force_issue) |=> ({cs_n, ras_n, cas_n, we_n} == 4'b0111));
   assert_viol_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_q != '0) |=> ((viol_q & $past(viol_q)) == $past(viol_q)));
endmodule

// File: tb/test_sdram_act_tracker.sv
module test_sdram_act_tracker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  req_cmd = 3'd0;
   logic [1:0]  req_bank = 2'd0;
   logic [10:0] req_addr = '0;
   logic        force_issue = 1'b0;
   logic        grant, stall, row_hit, cke, cs_n, ras_n, cas_n, we_n;
   logic [3:0]  bank_open;
   logic [5:0]  viol;
   logic [1:0]  ba;
   logic [10:0] addr;

   always #5 clk = ~clk;

   sdram_act_tracker i_sdram_act_tracker (
      .clk(clk), .rst_n(rst_n), .req_cmd(req_cmd), .req_bank(req_bank),
      .req_addr(req_addr), .force_issue(force_issue), .grant(grant), .stall(stall),
      .row_hit(row_hit), .bank_open(bank_open), .viol(viol), .cke(cke),
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr));

   int  n_chk = 0;
   int  n_err = 0;
   bit  done = 1'b0;

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [3:0] pinv();
      return {cs_n, ras_n, cas_n, we_n};
   endfunction

   task automatic drive(input logic [2:0] c, input logic [1:0] b, input logic [10:0] a, input logic f);
      @(negedge clk);
      req_cmd = c; req_bank = b; req_addr = a; force_issue = f;
      #1;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   typedef struct packed {
      logic [15:0] tag;
      logic [2:0]  cmd;
      logic [1:0]  bank;
      logic [10:0] a;
      logic        gnt;
      logic [3:0]  pins;
      logic [3:0]  opn;
   } vec_t;

   // pins: NOP 0111, ACT 0011, RD 0101, WR 0100, PRE 0010
   localparam vec_t TBL [20] = '{
      '{"R2", 3'd2, 2'd0, 11'h000, 1'b0, 4'b0111, 4'b0000},
      '{"R1", 3'd1, 2'd0, 11'h005, 1'b1, 4'b0011, 4'b0001},
      '{"R3", 3'd2, 2'd0, 11'h010, 1'b0, 4'b0111, 4'b0001},
      '{"R3", 3'd3, 2'd0, 11'h011, 1'b1, 4'b0100, 4'b0001},
      '{"R6", 3'd1, 2'd1, 11'h006, 1'b1, 4'b0011, 4'b0011},
      '{"R6", 3'd1, 2'd2, 11'h007, 1'b0, 4'b0111, 4'b0011},
      '{"R6", 3'd1, 2'd2, 11'h007, 1'b1, 4'b0011, 4'b0111},
      '{"R4", 3'd1, 2'd0, 11'h008, 1'b0, 4'b0111, 4'b0111},
      '{"R7", 3'd4, 2'd0, 11'h000, 1'b1, 4'b0010, 4'b0110},
      '{"R7", 3'd1, 2'd0, 11'h009, 1'b0, 4'b0111, 4'b0110},
      '{"R7", 3'd1, 2'd0, 11'h009, 1'b1, 4'b0011, 4'b0111},
      '{"R7", 3'd4, 2'd0, 11'h400, 1'b1, 4'b0010, 4'b0110},
      '{"R8", 3'd0, 2'd0, 11'h000, 1'b1, 4'b0111, 4'b0110},
      '{"R8", 3'd0, 2'd0, 11'h000, 1'b1, 4'b0111, 4'b0110},
      '{"R8", 3'd0, 2'd0, 11'h000, 1'b1, 4'b0111, 4'b0110},
      '{"R8", 3'd0, 2'd0, 11'h000, 1'b1, 4'b0111, 4'b0110},
      '{"R5", 3'd1, 2'd0, 11'h02A, 1'b0, 4'b0111, 4'b0110},
      '{"R5", 3'd1, 2'd0, 11'h02A, 1'b1, 4'b0011, 4'b0111},
      '{"R8", 3'd2, 2'd2, 11'h033, 1'b1, 4'b0101, 4'b0111},
      '{"R8", 3'd7, 2'd1, 11'h000, 1'b1, 4'b0111, 4'b0111}
   };

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; req_cmd = 3'd0; req_bank = 2'd0; req_addr = '0; force_issue = 1'b0;
      tick(); tick();
      chk("R10", "pins in reset", 32'(pinv()), 32'h7);
      chk("R10", "cke in reset", 32'(cke), 32'h0);
      chk("R10", "open in reset", 32'(bank_open), 32'h0);
      chk("R10", "viol in reset", 32'(viol), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      tick();
      chk("R10", "cke after reset", 32'(cke), 32'h1);
   endtask

   initial begin
      do_reset();

      foreach (TBL[i]) begin
         drive(TBL[i].cmd, TBL[i].bank, TBL[i].a, 1'b0);
         chk(string'(TBL[i].tag), $sformatf("grant v%0d", i), 32'(grant), 32'(TBL[i].gnt));
         chk(string'(TBL[i].tag), $sformatf("stall v%0d", i), 32'(stall), 32'(!TBL[i].gnt));
         tick();
         chk(string'(TBL[i].tag), $sformatf("pins v%0d", i), 32'(pinv()), 32'(TBL[i].pins));
         chk(string'(TBL[i].tag), $sformatf("open v%0d", i), 32'(bank_open), 32'(TBL[i].opn));
         if (TBL[i].gnt && TBL[i].pins != 4'b0111) begin
            chk("R8", $sformatf("ba v%0d", i), 32'(ba), 32'(TBL[i].bank));
            chk("R8", $sformatf("addr v%0d", i), 32'(addr), 32'(TBL[i].a));
         end
      end

      // R11: bank 0 holds row 02A, bank 3 is closed
      drive(3'd0, 2'd0, 11'h02A, 1'b0);
      chk("R11", "row match", 32'(row_hit), 32'h1);
      drive(3'd0, 2'd0, 11'h02B, 1'b0);
      chk("R11", "row mismatch", 32'(row_hit), 32'h0);
      drive(3'd0, 2'd3, 11'h000, 1'b0);
      chk("R11", "closed bank", 32'(row_hit), 32'h0);
      tick();

      // R9: forced commands and sticky violation bits
      do_reset();
      drive(3'd2, 2'd3, 11'h001, 1'b1);
      chk("R9", "forced RD stall", 32'(stall), 32'h1);
      tick();
      chk("R9", "forced RD pins", 32'(pinv()), 32'h5);
      chk("R9", "closed access bit", 32'(viol), 32'h01);
      drive(3'd1, 2'd3, 11'h010, 1'b1);
      chk("R9", "legal forced ACT grant", 32'(grant), 32'h1);
      tick();
      chk("R9", "no new bit", 32'(viol), 32'h01);
      drive(3'd1, 2'd3, 11'h011, 1'b1);
      tick();
      chk("R9", "open/rc/rrd bits", 32'(viol), 32'h1D);
      chk("R9", "forced ACT pins", 32'(pinv()), 32'h3);
      drive(3'd2, 2'd3, 11'h002, 1'b1);
      tick();
      chk("R9", "rcd bit", 32'(viol), 32'h1F);
      drive(3'd4, 2'd3, 11'h000, 1'b0);
      tick();
      drive(3'd1, 2'd3, 11'h012, 1'b1);
      tick();
      chk("R9", "rp bit", 32'(viol), 32'h3F);
      chk("R9", "forced ACT opens", 32'(bank_open), 32'h8);
      for (int k = 0; k < 3; k++) begin
         drive(3'd0, 2'd0, 11'h000, 1'b0);
         tick();
      end
      chk("R9", "sticky hold", 32'(viol), 32'h3F);
      do_reset();
      chk("R10", "viol cleared by reset", 32'(viol), 32'h0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule